// File: doc/BRIEF.md
# Power-Manager Serial Control Register File

This block is the serial-slave control front end of a battery power-management controller. A host writes 8-bit frames over a four-wire serial port (chip select low-active, clock, data in, data out). Each accepted frame either loads one of three 5-bit control registers or, when its top bit is set, loads the 7-bit code of the comparator threshold DAC. While the frame's bits are shifted in, the block shifts a status byte out. The status byte carries three comparator results and the low-battery flag.

From the stored bits the block derives the gated control outputs. These are the converter enable, run or coast mode, the two low-noise regulator enables, two switch drivers (one of them gated by an external tone input), the high or low charge current, and the backup-regulator enable. The backup regulator turns on either on command or automatically when the battery runs low. The analog parts sit outside the block and appear here only as enables and status inputs.

The serial pins are oversampled by the system clock through a synchronizer. A frame state machine has four states: IDLE (chip select high), SHIFT (fewer than 8 clocks seen), FULL (exactly 8 seen) and OVER (more than 8 seen). Its transitions are IDLE to SHIFT on chip-select fall, SHIFT to FULL on the 8th rising clock, FULL to OVER on any further rising clock, and SHIFT, FULL or OVER to IDLE on chip-select rise. A commit happens only on the FULL to IDLE transition.

Top module: `pm_ctrl_regfile`

## Requirements
- R1: Data in is sampled on rising serial-clock edges while chip select is low, MSB first. Registers change only when chip select rises after exactly 8 rising edges. A frame with 7 or fewer, or 9 or more, rising edges changes nothing.
- R2: When frame bit 7 is 1, frame bits 6:0 load the DAC code. When bit 7 is 0, bits 6:5 select a register (00 switch, 01 power, 10 output voltage) and bits 4:0 are its data. Selector 11 has no effect on any output.
- R3: Switch register bit positions are: 4 driver-2 enable, 3 driver-1 enable, 2 run (1) or coast (0), 1 regulator-2 enable, 0 regulator-3 enable. These bits drive `drv1_on`, `run_mode`, `reg2_en` and `reg3_en`.
- R4: Power register bit positions are: 4 automatic backup on low battery, 3 high charge current, 2 low charge current, 1 backup enable. Bit 0 is not stored.
- R5: The output-voltage register holds a 5-bit code n that selects 1.8 V + n x 0.1 V (0 to 31, so 1.8 V to 4.9 V) and appears on `vsel`.
- R6: While `rst_n` is low, and after it is released, the block is in the power-on state. Run is 0 (coast), `conv_en` is 1, every other enable is 0, `dac_code` is 0, `vsel` is 12 (3.0 V) and the held channel results are 0.
- R7: `backup_on` is 1 when the backup bit is set, or when the automatic bit is set and `low_batt` is 1. While it is 1, `conv_en`, `run_mode`, `chg_hi` and `chg_lo` are all 0.
- R8: When both charge bits are set, only `chg_hi` is 1. `chg_lo` is 1 only when the low bit is set alone.
- R9: `drv2_on` is the driver-2 enable bit ANDed with `drv2_gate`.
- R10: `spi_miso` is 0 while chip select is high. When chip select falls, `spi_miso` shows status bit 7. It advances one bit on each falling serial-clock edge that follows a rising edge.
- R11: The status byte is laid out as: bit 7 channel 2, bit 6 channel 1, bit 5 channel 0, bit 4 `low_batt` sampled at chip-select fall, and bits 3:0 zero.
- R12: The channel results are captured from `cmp_ch*` when an accepted frame commits, and are reported in the next frame. Discarded frames capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset to the power-on state |
| spi_sck | input | 1 | Serial clock |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial status data out of the block |
| low_batt | input | 1 | Low-battery comparator result, 1 = low |
| cmp_ch0 | input | 1 | Channel 0 comparator result |
| cmp_ch1 | input | 1 | Channel 1 comparator result |
| cmp_ch2 | input | 1 | Channel 2 comparator result |
| drv2_gate | input | 1 | External gating for driver 2 |
| conv_en | output | 1 | Switching converter enable |
| run_mode | output | 1 | 1 = run (PWM), 0 = coast |
| reg2_en | output | 1 | Regulator 2 enable |
| reg3_en | output | 1 | Regulator 3 enable |
| drv1_on | output | 1 | Driver 1 switch on |
| drv2_on | output | 1 | Driver 2 switch on |
| chg_hi | output | 1 | High charge current on |
| chg_lo | output | 1 | Low charge current on |
| backup_on | output | 1 | Backup regulator on |
| vsel | output | 5 | Output-voltage code |
| dac_code | output | 7 | Threshold DAC code |

## Verification
The low-battery input can change in the same cycle in which a frame commits a new power-register value. The automatic-backup override then has to act on the new register bits and the new battery flag together. The bench provokes this by toggling `low_batt` at the same instant that it raises chip select, on directed frames that set the automatic and charge bits and on random frames. After the commit has settled, it compares all gated outputs against a model built from the final register image and the final flag. The status byte of that frame is judged against the flag value from before the toggle.

// File: rtl/pm_ctrl_pkg.sv
package pm_ctrl_pkg;
    localparam int FRAME_W = 8;
    localparam int DATA_W  = 5;
    localparam int DAC_W   = FRAME_W - 1;
    localparam int VSEL_W  = DATA_W;
    localparam int PWR_W   = DATA_W - 1;
    localparam int CH_N    = 3;
    localparam logic [VSEL_W-1:0] VSEL_POR = VSEL_W'(12);

    // switch register bit positions
    localparam int A_DRV2 = 4;
    localparam int A_DRV1 = 3;
    localparam int A_RUN  = 2;
    localparam int A_REG2 = 1;
    localparam int A_REG3 = 0;
    // power register, stored from frame bits 4:1
    localparam int B_AUTO  = 3;
    localparam int B_CHG15 = 2;
    localparam int B_CHG1  = 1;
    localparam int B_BKUP  = 0;

    typedef enum logic [1:0] {
        SEL_SWITCH = 2'b00,
        SEL_POWER  = 2'b01,
        SEL_VOUT   = 2'b10,
        SEL_SPARE  = 2'b11
    } reg_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FULL,
        ST_OVER
    } frame_st_t;
endpackage

// File: rtl/pm_pin_sync.sv
module pm_pin_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES < 1) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [W-1:0] stg [STAGES];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end
            assign q = stg[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pm_frame_fsm.sv
module pm_frame_fsm
    import pm_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               csn_s,
    input  logic               mosi_s,
    input  logic [FRAME_W-1:0] status,
    output logic               commit,
    output logic [FRAME_W-1:0] frame,
    output logic               miso
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    frame_st_t          state, nstate;
    logic               sck_q, csn_q;
    logic               sck_rise, sck_fall, cs_fall, cs_rise;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] rx_sh, tx_sh;
    logic               seen_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            sck_q <= sck_s;
            csn_q <= csn_s;
        end
    end

    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;
    assign cs_fall  = ~csn_s & csn_q;
    assign cs_rise  = csn_s & ~csn_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (cs_fall) nstate = ST_SHIFT;
            ST_SHIFT: if (cs_rise) nstate = ST_IDLE;
                      else if (sck_rise && cnt == LAST) nstate = ST_FULL;
            ST_FULL:  if (cs_rise) nstate = ST_IDLE;
                      else if (sck_rise) nstate = ST_OVER;
            ST_OVER:  if (cs_rise) nstate = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            seen_rise <= 1'b0;
            commit    <= 1'b0;
        end else begin
            commit <= (state == ST_FULL) && cs_rise;
            if (state == ST_IDLE) begin
                if (cs_fall) begin
                    cnt       <= '0;
                    seen_rise <= 1'b0;
                    tx_sh     <= status;
                end
            end else begin
                if (sck_rise) begin
                    seen_rise <= 1'b1;
                end else if (sck_fall && seen_rise) begin
                    seen_rise <= 1'b0;
                    tx_sh     <= {tx_sh[FRAME_W-2:0], 1'b0};
                end
                if (state == ST_SHIFT && sck_rise && !cs_rise) begin
                    rx_sh <= {rx_sh[FRAME_W-2:0], mosi_s};
                    cnt   <= cnt + 1'b1;
                end
            end
        end
    end

    assign frame = rx_sh;
    assign miso  = (state != ST_IDLE) & tx_sh[FRAME_W-1];

    // R1
    over_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OVER) |=> (state == ST_OVER || state == ST_IDLE));
    // R1
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (state == ST_IDLE) ##1 !commit);
    // R10
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) && !sck_fall |=> $stable(tx_sh));
endmodule

// File: rtl/pm_reg_bank.sv
module pm_reg_bank
    import pm_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CH_N-1:0]    cmp,
    input  logic               low_batt,
    output logic [DATA_W-1:0]  ctl_a,
    output logic [PWR_W-1:0]   ctl_b,
    output logic [VSEL_W-1:0]  vsel,
    output logic [DAC_W-1:0]   dac,
    output logic [FRAME_W-1:0] status
);
    logic [CH_N-1:0] ch_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_a   <= '0;
            ctl_b   <= '0;
            vsel    <= VSEL_POR;
            dac     <= '0;
            ch_hold <= '0;
        end else if (commit) begin
            ch_hold <= cmp;
            if (frame[FRAME_W-1]) begin
                dac <= frame[DAC_W-1:0];
            end else begin
                unique case (reg_sel_t'(frame[6:5]))
                    SEL_SWITCH: ctl_a <= frame[DATA_W-1:0];
                    SEL_POWER:  ctl_b <= frame[DATA_W-1:1];
                    SEL_VOUT:   vsel  <= frame[VSEL_W-1:0];
                    SEL_SPARE:  ;
                endcase
            end
        end
    end

    assign status = {ch_hold, low_batt, {(FRAME_W-CH_N-1){1'b0}}};

    // R1
    no_commit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(ctl_a) && $stable(ctl_b) && $stable(vsel)
                    && $stable(dac) && $stable(ch_hold));
    // R2
    dac_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && frame[FRAME_W-1] |=> $stable(ctl_a) && $stable(ctl_b) && $stable(vsel));
    // R12
    hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ch_hold == $past(cmp));
endmodule

// File: rtl/pm_out_logic.sv
module pm_out_logic
    import pm_ctrl_pkg::*;
(
    input  logic [DATA_W-1:0] ctl_a,
    input  logic [PWR_W-1:0]  ctl_b,
    input  logic              low_batt,
    input  logic              drv2_gate,
    output logic              conv_en,
    output logic              run_mode,
    output logic              reg2_en,
    output logic              reg3_en,
    output logic              drv1_on,
    output logic              drv2_on,
    output logic              chg_hi,
    output logic              chg_lo,
    output logic              backup_on
);
    logic bk;

    always_comb begin
        bk        = ctl_b[B_BKUP] | (ctl_b[B_AUTO] & low_batt);
        backup_on = bk;
        conv_en   = ~bk;
        run_mode  = ctl_a[A_RUN] & ~bk;
        chg_hi    = ctl_b[B_CHG15] & ~bk;
        chg_lo    = ctl_b[B_CHG1] & ~ctl_b[B_CHG15] & ~bk;
        reg2_en   = ctl_a[A_REG2];
        reg3_en   = ctl_a[A_REG3];
        drv1_on   = ctl_a[A_DRV1];
        drv2_on   = ctl_a[A_DRV2] & drv2_gate;
    end
endmodule

// File: rtl/pm_ctrl_regfile.sv
module pm_ctrl_regfile
    import pm_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              low_batt,
    input  logic              cmp_ch0,
    input  logic              cmp_ch1,
    input  logic              cmp_ch2,
    input  logic              drv2_gate,
    output logic              conv_en,
    output logic              run_mode,
    output logic              reg2_en,
    output logic              reg3_en,
    output logic              drv1_on,
    output logic              drv2_on,
    output logic              chg_hi,
    output logic              chg_lo,
    output logic              backup_on,
    output logic [VSEL_W-1:0] vsel,
    output logic [DAC_W-1:0]  dac_code
);
    logic [2:0]         pins_s;
    logic               commit;
    logic [FRAME_W-1:0] frame, status;
    logic [DATA_W-1:0]  ctl_a;
    logic [PWR_W-1:0]   ctl_b;

    pm_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sck, spi_csn, spi_mosi}), .q(pins_s)
    );

    pm_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sck_s(pins_s[2]), .csn_s(pins_s[1]), .mosi_s(pins_s[0]),
        .status(status), .commit(commit), .frame(frame), .miso(spi_miso)
    );

    pm_reg_bank u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .frame(frame),
        .cmp({cmp_ch2, cmp_ch1, cmp_ch0}), .low_batt(low_batt),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .vsel(vsel), .dac(dac_code), .status(status)
    );

    pm_out_logic u_out (
        .ctl_a(ctl_a), .ctl_b(ctl_b), .low_batt(low_batt), .drv2_gate(drv2_gate),
        .conv_en(conv_en), .run_mode(run_mode), .reg2_en(reg2_en), .reg3_en(reg3_en),
        .drv1_on(drv1_on), .drv2_on(drv2_on), .chg_hi(chg_hi), .chg_lo(chg_lo),
        .backup_on(backup_on)
    );

    // R7
    backup_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        backup_on |-> !conv_en && !run_mode && !chg_hi && !chg_lo);
    // R8
    charge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_hi && chg_lo));
    // R9
    drv2_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv2_on |-> drv2_gate);
    // R10
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn && $past(spi_csn) && pins_s[1] && $past(pins_s[1]) |-> !spi_miso);
endmodule

// File: tb/pm_ctrl_regfile_bench.sv
`timescale 1ns/1ps
module pm_ctrl_regfile_bench;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
    logic low_batt = 1'b0, cmp_ch0 = 1'b0, cmp_ch1 = 1'b0, cmp_ch2 = 1'b0;
    logic drv2_gate = 1'b0;
    logic spi_miso, conv_en, run_mode, reg2_en, reg3_en, drv1_on, drv2_on;
    logic chg_hi, chg_lo, backup_on;
    logic [4:0] vsel;
    logic [6:0] dac_code;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    logic [4:0] m_a, m_b, m_v;
    logic [6:0] m_d;
    logic [2:0] m_hold;

    always #2.5 clk = ~clk;

    pm_ctrl_regfile u_pm_ctrl_regfile (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [20:0] exp_outs();
        logic bk;
        bk = m_b[1] | (m_b[4] & low_batt);
        return {~bk, m_a[2] & ~bk, m_a[1], m_a[0], m_a[3], m_a[4] & drv2_gate,
                m_b[3] & ~bk, m_b[2] & ~m_b[3] & ~bk, bk, m_v, m_d};
    endfunction

    function automatic logic [20:0] act_outs();
        return {conv_en, run_mode, reg2_en, reg3_en, drv1_on, drv2_on,
                chg_hi, chg_lo, backup_on, vsel, dac_code};
    endfunction

    task automatic model_reset();
        m_a = '0; m_b = '0; m_v = 5'd12; m_d = '0; m_hold = '0;
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, input bit flip,
                        input string req);
        logic [7:0] rx, exp_st, mask;
        exp_st = {m_hold, low_batt, 4'b0000};
        rx = '0;
        @(negedge clk); spi_csn = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 8) ? tx[7-i] : 1'b1;
            repeat (H) @(negedge clk);
            if (i < 8) rx[7-i] = spi_miso;
            spi_sck = 1'b1;
            repeat (H) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        spi_csn = 1'b1;
        if (flip) low_batt = ~low_batt;
        repeat (3*H) @(negedge clk);
        mask = (nbits >= 8) ? 8'hFF : ~(8'hFF >> nbits);
        chk({req, " R10 R11 status"}, rx & mask, exp_st & mask);
        if (nbits == 8) begin
            m_hold = {cmp_ch2, cmp_ch1, cmp_ch0};
            if (tx[7]) m_d = tx[6:0];
            else case (tx[6:5])
                2'b00: m_a = tx[4:0];
                2'b01: m_b = tx[4:0];
                2'b10: m_v = tx[4:0];
                default: ;
            endcase
        end
        chk({req, " outputs"}, act_outs(), exp_outs());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (5) @(negedge clk);
        chk("R6 reset outputs", act_outs(), exp_outs());
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 after release", act_outs(), exp_outs());
        chk("R10 idle miso", spi_miso, 0);

        // R3 switch register, R9 gate
        xfer(8'b0001_1111, 8, 0, "R3 all switch bits");
        chk("R9 gate low", drv2_on, 0);
        drv2_gate = 1'b1; repeat (2) @(negedge clk);
        chk("R9 gate high", drv2_on, 1);
        xfer(8'b0000_0100, 8, 0, "R3 run only");
        // R4 R8 charger
        xfer(8'b0010_1100, 8, 0, "R8 both charge bits");
        chk("R8 hi wins", {chg_hi, chg_lo}, 2'b10);
        xfer(8'b0010_0100, 8, 0, "R4 low charge");
        chk("R8 lo alone", {chg_hi, chg_lo}, 2'b01);
        // R7 backup
        xfer(8'b0010_0010, 8, 0, "R7 backup bit");
        chk("R7 converter off", {backup_on, conv_en}, 2'b10);
        xfer(8'b0011_1000, 8, 0, "R7 auto armed");
        chk("R7 auto idle", backup_on, 0);
        low_batt = 1'b1; repeat (2) @(negedge clk);
        chk("R7 auto fires", {backup_on, chg_hi, run_mode}, 3'b100);
        low_batt = 1'b0;
        // R5 voltage code
        xfer(8'b0100_0000, 8, 0, "R5 code 0");
        xfer(8'b0101_1111, 8, 0, "R5 code 31");
        // R2 DAC and spare selector
        xfer(8'hFF, 8, 0, "R2 dac max");
        xfer(8'b0111_0101, 8, 0, "R2 spare selector ignored");
        xfer(8'h80, 8, 0, "R2 dac zero");
        // R12 lateness and R1 discards
        {cmp_ch2, cmp_ch1, cmp_ch0} = 3'b101;
        xfer(8'h81, 8, 0, "R12 capture");
        {cmp_ch2, cmp_ch1, cmp_ch0} = 3'b010;
        xfer(8'h9A, 7, 0, "R1 short frame");
        xfer(8'hA5, 9, 0, "R1 long frame");
        xfer(8'h82, 8, 0, "R12 reports previous");
        // concurrent commit and low-battery change
        xfer(8'b0011_1100, 8, 1, "R7 concurrent flip");
        xfer(8'b0010_1000, 8, 1, "R7 concurrent flip back");
        // mid-run reset
        {cmp_ch2, cmp_ch1, cmp_ch0} = 3'b111;
        xfer(8'b0001_0101, 8, 0, "R6 pre reset");
        rst_n = 1'b0; model_reset(); repeat (3) @(negedge clk);
        chk("R6 mid-run reset", act_outs(), exp_outs());
        rst_n = 1'b1; repeat (3) @(negedge clk);
        xfer(8'b0111_1111, 8, 0, "R6 hold cleared");

        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [7:0] b;
            int n, r;
            bit fl;
            b = 8'($urandom);
            r = $urandom_range(0, 9);
            n = (r == 0) ? 7 : (r == 1) ? 9 : (r == 2) ? $urandom_range(1, 6) : 8;
            fl = ($urandom_range(0, 7) == 0);
            {cmp_ch2, cmp_ch1, cmp_ch0} = 3'($urandom);
            low_batt = 1'($urandom);
            drv2_gate = 1'($urandom);
            repeat (2) @(negedge clk);
            xfer(b, n, fl, "R1 R2 R12 random");
        end
        chk("R10 idle end", spi_miso, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule